// File: doc/BRIEF.md
# Probability-Ranked Transition Bus Codec

This block joins two ends of a point-to-point on-chip link that carries one data word per beat. It lowers the switching on the link wires without widening the link. At the sending end, a loadable permutation table gives each data value a rank. Rank 0 is meant for the value seen most often, and higher ranks go to rarer values. The rank selects a codeword of the same width as the data. Codewords are listed by rising number of one-bits and, within one weight, by rising numeric value. The codeword is then sent as transitions: each one-bit flips its wire, and each zero-bit leaves its wire at its old level.

At the receiving end, the new bus value is XORed with the last bus value held there. This gives back the codeword. The codeword is turned back into its rank, and an inverse table turns the rank into the data word. Both ends clear their bus reference together at reset. Each end adds one cycle of latency, and a valid flag travels beside the word.

Software loads the table with single writes. Each write gives a chosen data value a chosen rank, and the value that held that rank takes the old rank of the written value. The table therefore stays a permutation after every write.

Top module: `rank_xbus_codec`

## Requirements
- R1: The link carries exactly DATA_W wires, the same as the data width, with no extra coding or control wires beside the valid flag.
- R2: Rank r selects the r-th codeword in an order sorted by number of ones, then by numeric value. Rank 0 is all zeros, ranks 1..DATA_W are the single-one words from bit 0 upward, and the next ranks are 0x03, 0x05, 0x06, 0x09 and so on.
- R3: On a beat with in_valid high, link_bus takes the value of its previous state XORed with the codeword of the word's rank, one clock after the beat.
- R4: In a cycle with in_valid low, link_bus keeps its value.
- R5: A beat toggles exactly as many wires as its codeword has ones. A rank-0 word toggles none, and words of ranks 1..DATA_W toggle exactly one.
- R6: While reset is held, link_bus is zero and both valid outputs are low. After reset, the table is the identity (data value v has rank v).
- R7: A configuration write of (word a, rank r) gives a rank r and gives the word that held rank r the former rank of a. The table stays a permutation of all 2^DATA_W values.
- R8: out_valid rises two clocks after in_valid, and out_data then equals the word that was sent.
- R9: link_valid equals in_valid delayed by one clock.
- R10: A configuration write must only occur while no beat is in flight (in_valid and link_valid both low). The written mapping applies at both ends from the next beat onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_word | input | DATA_W | Data value whose rank is written |
| cfg_rank | input | DATA_W | New rank for cfg_word |
| in_valid | input | 1 | Beat present at the sending end |
| in_data | input | DATA_W | Word to send |
| link_valid | output | 1 | Beat present on the link |
| link_bus | output | DATA_W | Transition-coded link wires |
| out_valid | output | 1 | Decoded word present |
| out_data | output | DATA_W | Decoded word |

## Verification
The assertions assume the table is never written while a beat is between the encoder and the decoder. The round-trip check compares against the word from two cycles earlier, so it only holds if both ends used the same mapping. The bench follows this rule: it waits for two idle cycles before every configuration write, and it raises in_valid again only after the write strobe has dropped. Random traffic mixes idle cycles with valid beats, so the hold-on-idle rule is tested between beats as well as across beats.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    // Binomial coefficient C(n, k); zero outside 0 <= k <= n.
    function automatic int binom(input int n, input int k);
        int res;
        if (k < 0 || k > n) return 0;
        res = 1;
        for (int i = 1; i <= k; i++) res = res * (n - k + i) / i;
        return res;
    endfunction

    // Position of codeword cw in the weight-then-value enumeration of width w.
    function automatic int cw_to_rank(input int cw, input int w);
        int k;
        int base;
        int idx;
        int seen;
        k = 0;
        base = 0;
        idx = 0;
        seen = 0;
        for (int p = 0; p < w; p++) k += (cw >> p) & 1;
        for (int j = 0; j < k; j++) base += binom(w, j);
        for (int p = 0; p < w; p++) begin
            if (((cw >> p) & 1) == 1) begin
                seen++;
                idx += binom(p, seen);
            end
        end
        return base + idx;
    endfunction

    // Codeword at position r of the weight-then-value enumeration of width w.
    function automatic int rank_to_cw(input int r, input int w);
        int rem;
        int k;
        int cw;
        int p;
        bit done;
        rem = r;
        k = 0;
        cw = 0;
        done = 1'b0;
        for (int j = 0; j <= w; j++) begin
            if (!done) begin
                if (rem >= binom(w, j)) rem -= binom(w, j);
                else begin
                    k = j;
                    done = 1'b1;
                end
            end
        end
        for (int i = w; i >= 1; i--) begin
            if (i <= k) begin
                p = i - 1;
                for (int q = i; q < w; q++) if (binom(q, i) <= rem) p = q;
                cw = cw | (1 << p);
                rem -= binom(p, i);
            end
        end
        return cw;
    endfunction

endpackage

// File: rtl/rxc_perm_table.sv
module rxc_perm_table #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_rank,
    input  logic [DATA_W-1:0] fwd_word,
    output logic [DATA_W-1:0] fwd_rank,
    input  logic [DATA_W-1:0] inv_rank,
    output logic [DATA_W-1:0] inv_word
);
    localparam int DEPTH = 1 << DATA_W;

    typedef logic [DEPTH-1:0][DATA_W-1:0] vec_t;
    typedef struct packed {
        vec_t fwd;
        vec_t inv;
    } tbl_t;

    tbl_t              tbl_d, tbl_q;
    logic [DATA_W-1:0] old_rank;
    logic [DATA_W-1:0] displaced;

    // Swap-style write: the table remains a permutation after every write.
    always_comb begin
        tbl_d     = tbl_q;
        old_rank  = tbl_q.fwd[wr_word];
        displaced = tbl_q.inv[wr_rank];
        if (wr_en) begin
            tbl_d.fwd[displaced] = old_rank;
            tbl_d.fwd[wr_word]   = wr_rank;
            tbl_d.inv[old_rank]  = displaced;
            tbl_d.inv[wr_rank]   = wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q.fwd[i] <= DATA_W'(i);
                tbl_q.inv[i] <= DATA_W'(i);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign fwd_rank = tbl_q.fwd[fwd_word];
    assign inv_word = tbl_q.inv[inv_rank];
endmodule

// File: rtl/rxc_encoder.sv
module rxc_encoder #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic [DATA_W-1:0] beat_rank,
    output logic              bus_valid,
    output logic [DATA_W-1:0] bus_o
);
    import rxc_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] bus;
        logic              vld;
    } enc_st_t;

    enc_st_t           st_d, st_q;
    logic [DATA_W-1:0] codeword;

    always_comb begin
        codeword = DATA_W'(rank_to_cw(int'(beat_rank), DATA_W));
        st_d     = st_q;
        st_d.vld = beat_valid;
        if (beat_valid) st_d.bus = st_q.bus ^ codeword;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_o     = st_q.bus;
    assign bus_valid = st_q.vld;
endmodule

// File: rtl/rxc_decoder.sv
module rxc_decoder #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] lookup_rank,
    input  logic [DATA_W-1:0] lookup_word,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_o
);
    import rxc_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] ref_bus;
        logic [DATA_W-1:0] word;
        logic              vld;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        lookup_rank = DATA_W'(cw_to_rank(int'(bus_i ^ st_q.ref_bus), DATA_W));
        st_d        = st_q;
        st_d.vld    = bus_valid;
        if (bus_valid) begin
            st_d.ref_bus = bus_i;
            st_d.word    = lookup_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o     = st_q.word;
    assign word_valid = st_q.vld;
endmodule

// File: rtl/rank_xbus_codec.sv
module rank_xbus_codec #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic [DATA_W-1:0] cfg_rank,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              link_valid,
    output logic [DATA_W-1:0] link_bus,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] enc_rank;
    logic [DATA_W-1:0] dec_rank;
    logic [DATA_W-1:0] dec_word;

    rxc_perm_table #(.DATA_W(DATA_W)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_word  (cfg_word),
        .wr_rank  (cfg_rank),
        .fwd_word (in_data),
        .fwd_rank (enc_rank),
        .inv_rank (dec_rank),
        .inv_word (dec_word)
    );

    rxc_encoder #(.DATA_W(DATA_W)) i_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (in_valid),
        .beat_rank  (enc_rank),
        .bus_valid  (link_valid),
        .bus_o      (link_bus)
    );

    rxc_decoder #(.DATA_W(DATA_W)) i_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (link_valid),
        .bus_i       (link_bus),
        .lookup_rank (dec_rank),
        .lookup_word (dec_word),
        .word_valid  (out_valid),
        .word_o      (out_data)
    );
endmodule

// File: rtl/rxc_codec_checker.sv
module rxc_codec_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [DATA_W-1:0] enc_rank,
    input logic              link_valid,
    input logic [DATA_W-1:0] link_bus,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(link_bus)); // R4

    AST_RANK0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_rank == '0) |=> $stable(link_bus)); // R5

    AST_LOW_RANK_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(enc_rank) <= DATA_W) |=> $countones(link_bus ^ $past(link_bus)) <= 1); // R5

    AST_LINK_VALID_UP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> link_valid); // R9

    AST_LINK_VALID_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !link_valid); // R9

    AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |=> (out_valid && out_data == $past(in_data, 2))); // R8

    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (!in_valid && !link_valid)); // R10

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (link_bus == '0 && !link_valid && !out_valid); // R6
        end
    end
endmodule

bind rank_xbus_codec rxc_codec_checker #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_rank_xbus_codec.sv
module test_rank_xbus_codec;
    localparam int W = 8;
    localparam int D = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         cfg_we;
    logic [W-1:0] cfg_word;
    logic [W-1:0] cfg_rank;
    logic         in_valid;
    logic [W-1:0] in_data;
    logic         link_valid;
    logic [W-1:0] link_bus;
    logic         out_valid;
    logic [W-1:0] out_data;

    int           n_chk = 0;
    int           n_bad = 0;
    int           exp_cw [D];
    int           model  [D];
    logic [W-1:0] exp_bus = '0;
    bit           p_v = 1'b0;
    int           p_d = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    rank_xbus_codec #(.DATA_W(W)) i_rank_xbus_codec (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .cfg_rank(cfg_rank), .in_valid(in_valid), .in_data(in_data),
        .link_valid(link_valid), .link_bus(link_bus),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int holder_of(input int r);
        for (int i = 0; i < D; i++) if (model[i] == r) return i;
        return 0;
    endfunction

    // One cycle: drive at a falling edge, sample at the next falling edge.
    task automatic tick(input bit v, input int d, input string tag);
        logic [W-1:0] prev;
        logic [W-1:0] cw;
        in_valid = v;
        in_data  = d[W-1:0];
        @(negedge clk);
        prev = exp_bus;
        cw   = '0;
        if (v) begin
            cw      = exp_cw[model[d]][W-1:0];
            exp_bus = exp_bus ^ cw;
        end
        chk(link_valid == v, "R9", int'(link_valid), int'(v));
        chk(link_bus == exp_bus, tag, int'(link_bus), int'(exp_bus));
        if (v) begin
            chk($countones(link_bus ^ prev) == $countones(cw), "R5",
                $countones(link_bus ^ prev), $countones(cw));
            if (model[d] == 0)
                chk(link_bus == prev, "R5", int'(link_bus ^ prev), 0);
            else if (model[d] <= W)
                chk($countones(link_bus ^ prev) == 1, "R5", $countones(link_bus ^ prev), 1);
        end else begin
            chk(link_bus == prev, "R4", int'(link_bus), int'(prev));
        end
        chk(out_valid == p_v, "R8", int'(out_valid), int'(p_v));
        if (p_v) chk(int'(out_data) == p_d, "R8", int'(out_data), p_d);
        p_v = v;
        p_d = d;
    endtask

    task automatic cfg(input int a, input int r);
        int b;
        int old;
        tick(1'b0, 0, "R4");
        tick(1'b0, 0, "R4");
        cfg_we   = 1'b1;
        cfg_word = a[W-1:0];
        cfg_rank = r[W-1:0];
        @(negedge clk);
        cfg_we = 1'b0;
        b   = holder_of(r);
        old = model[a];
        model[b] = old;
        model[a] = r;
        p_v = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        int seed;
        int w0;
        logic [W-1:0] prev;
        cnt = 0;
        for (int k = 0; k <= W; k++)
            for (int c = 0; c < D; c++)
                if ($countones(c[W-1:0]) == k) begin
                    exp_cw[cnt] = c;
                    cnt++;
                end
        for (int i = 0; i < D; i++) model[i] = i;
        seed = $urandom(32'h5eed_1234);

        rst_n = 1'b0; cfg_we = 1'b0; cfg_word = '0; cfg_rank = '0;
        in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        chk(link_bus == '0, "R6", int'(link_bus), 0);
        chk(!link_valid && !out_valid, "R6", int'({link_valid, out_valid}), 0);
        chk($bits(link_bus) == $bits(in_data), "R1", $bits(link_bus), $bits(in_data));
        rst_n = 1'b1;

        // Identity table after reset; enumeration order check on low ranks
        for (int v = 0; v <= 12; v++) tick(1'b1, v, "R6");
        chk(exp_cw[9] == 3 && exp_cw[10] == 5 && exp_cw[11] == 6, "R2", exp_cw[10], 5);
        tick(1'b0, 0, "R4");
        tick(1'b0, 0, "R4");

        // Directed swap: word 5 takes rank 0, word 0 takes rank 5
        cfg(5, 0);
        prev = exp_bus;
        tick(1'b1, 5, "R10");
        chk(link_bus == prev, "R10", int'(link_bus ^ prev), 0);
        prev = exp_bus;
        tick(1'b1, 0, "R7");
        chk((link_bus ^ prev) == 8'h10, "R7", int'(link_bus ^ prev), 'h10);
        tick(1'b0, 0, "R4");
        chk(int'(out_data) == 0, "R10", int'(out_data), 0);

        // Random permutation via swap writes, then sweep every value
        for (int i = 0; i < D; i++) cfg(i, int'($urandom % D));
        for (int v = 0; v < D; v++) tick(1'b1, v, "R7");
        tick(1'b0, 0, "R4");

        // Random traffic with idle gaps
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 4 == 0) tick(1'b0, 0, "R4");
            else tick(1'b1, int'($urandom % D), "R3");
        end

        // Most frequent word repeated, then ranks 1..W
        w0 = holder_of(0);
        for (int n = 0; n < 4; n++) tick(1'b1, w0, "R5");
        for (int r = 1; r <= W; r++) tick(1'b1, holder_of(r), "R2");
        tick(1'b0, 0, "R4");
        tick(1'b0, 0, "R4");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule